// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator

This block produces the timing strobes for an asynchronous serial port. It sits on the bus clock, which runs at one quarter of the oscillator frequency. It divides that clock down through two stages chosen by an 8-bit control byte. The first stage is a non-power-of-two prescaler that divides by 1, 3, 4 or 13. The second stage is a binary rate selector that divides by 2^0 up to 2^7. Out of the cascade comes a single-cycle 16x oversampling strobe. A second counter turns every sixteenth oversampling strobe into a one-per-bit strobe.

Software loads the control byte with a single-cycle write strobe, and the stored byte is always visible on a read-back port. Every write restarts both counters from zero, so the first strobes after a rate change are spaced correctly. The block also presents the full bit period in bus cycles, so that neighbouring frame logic can work out how long a character lasts. A boot-mode input makes the block come out of reset already set to the slow loader rate. Two test bits are stored and read back, but they change nothing.

Top module: `sci_rate_gen`

## Requirements
- R1: While reset is asserted and until the first write, the control byte reads 0x00, the period output reads 16, the oversampling strobe is high on every cycle, and the bit strobe is high on every 16th cycle.
- R2: Control bits [5:4] select the prescaler: code 0 divides by 1, code 1 divides by 3, code 2 divides by 4 and code 3 divides by 13.
- R3: Control bits [2:0] hold a rate code S, and the prescaled rate is further divided by 2^S.
- R4: The period output equals prescale × 16 × 2^S. It follows the stored control byte from the cycle after the write edge, and it changes at no other time.
- R5: The oversampling strobe is a one-cycle pulse that repeats every D = prescale × 2^S bus cycles.
- R6: The bit strobe is high only together with the oversampling strobe, on every 16th one.
- R7: A write restarts both counters. Counting the write edge as edge 0, the first oversampling strobe comes after edge D−1 and the first bit strobe after edge 16·D−1, whatever the counters held before the write.
- R8: Control bits 7 and 3 are test bits. They are stored and read back, and they have no effect on the period or on the strobes.
- R9: If the boot input is high when reset is released, the first clock edge loads the control byte with 0x33 (prescale 13, S = 3, period 1664) and restarts the counters. After that edge the boot input is ignored.
- R10: A write on the first edge after reset takes priority over the boot preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock (oscillator / 4) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| boot_i | input | 1 | Boot mode: preload the loader rate on the first edge after reset |
| wr_en_i | input | 1 | Write strobe for the control byte |
| wr_data_i | input | 8 | Control byte to write |
| rd_data_o | output | 8 | Stored control byte |
| period_o | output | 15 | Bus cycles per serial bit |
| os_tick_o | output | 1 | 16x oversampling strobe |
| bit_tick_o | output | 1 | One-per-bit strobe |

## Verification
The assertions check the invariants that hold on every cycle. The bit strobe always coincides with an oversampling strobe. The period is always a nonzero multiple of 16 and changes only when the stored byte changes. No oversampling strobe appears on two cycles in a row unless the divisor is one. The cycle right after a write carries no strobe unless the divisor is one. The exact spacing of the strobes for each prescaler code and rate code can only be shown by the bench scenarios, which count edges against values they compute themselves. The same holds for the restart after a write that lands in the middle of a count, the inertness of the test bits, the boot preload and its loss of priority to a write.

// File: rtl/sci_rate_pkg.sv
package sci_rate_pkg;

  localparam int unsigned RATE_W  = 3;
  localparam int unsigned PSEL_W  = 2;
  localparam int unsigned PRESC_W = 4;

  typedef struct packed {
    logic              tst_clr;
    logic              spare;
    logic [PSEL_W-1:0] psel;
    logic              tst_chk;
    logic [RATE_W-1:0] rsel;
  } baud_ctl_t;

  function automatic logic [PRESC_W-1:0] presc_of(input logic [PSEL_W-1:0] code);
    case (code)
      2'd0:    presc_of = 4'd1;
      2'd1:    presc_of = 4'd3;
      2'd2:    presc_of = 4'd4;
      default: presc_of = 4'd13;
    endcase
  endfunction

endpackage

// File: rtl/sci_rate_ctl.sv
module sci_rate_ctl
  import sci_rate_pkg::*;
#(
  parameter logic [7:0] BOOT_VAL = 8'h33
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      boot_i,
  input  logic      wr_en_i,
  input  logic [7:0] wr_data_i,
  output baud_ctl_t ctl_o,
  output logic      restart_o
);

  baud_ctl_t ctl_q, ctl_d;
  logic      armed_q, armed_d;
  logic      preload;

  always_comb begin
    preload   = !armed_q && boot_i && !wr_en_i;
    armed_d   = 1'b1;
    ctl_d     = ctl_q;
    if (wr_en_i) begin
      ctl_d = baud_ctl_t'(wr_data_i);
    end else if (preload) begin
      ctl_d = baud_ctl_t'(BOOT_VAL);
    end
    restart_o = wr_en_i || preload;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q   <= '0;
      armed_q <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      armed_q <= armed_d;
    end
  end

  assign ctl_o = ctl_q;

endmodule

// File: rtl/sci_rate_os_div.sv
module sci_rate_os_div #(
  parameter int unsigned DIV_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             last;

  always_comb begin
    last  = (cnt_q == div_i - DIV_W'(1));
    cnt_d = cnt_q + DIV_W'(1);
    if (restart_i || last) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick_o = last;

endmodule

// File: rtl/sci_rate_bit_div.sv
module sci_rate_bit_div #(
  parameter int unsigned OS_LOG2 = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic restart_i,
  input  logic os_tick_i,
  output logic bit_tick_o
);

  localparam logic [OS_LOG2-1:0] SUB_LAST = '1;

  logic [OS_LOG2-1:0] sub_q, sub_d;
  logic               sub_en;

  always_comb begin
    sub_en = restart_i || os_tick_i;
    sub_d  = restart_i ? '0 : sub_q + OS_LOG2'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
    end else if (sub_en) begin
      sub_q <= sub_d;
    end
  end

  assign bit_tick_o = os_tick_i && (sub_q == SUB_LAST);

endmodule

// File: rtl/sci_rate_gen.sv
module sci_rate_gen
  import sci_rate_pkg::*;
#(
  parameter int unsigned OS_LOG2  = 4,
  parameter logic [7:0]  BOOT_VAL = 8'h33,
  localparam int unsigned OS_DIV_W = PRESC_W + (2 ** RATE_W) - 1,
  localparam int unsigned PER_W    = OS_DIV_W + OS_LOG2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             boot_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  output logic [7:0]       rd_data_o,
  output logic [PER_W-1:0] period_o,
  output logic             os_tick_o,
  output logic             bit_tick_o
);

  baud_ctl_t           ctl;
  logic                restart;
  logic [OS_DIV_W-1:0] os_div;

  sci_rate_ctl #(.BOOT_VAL(BOOT_VAL)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .boot_i   (boot_i),
    .wr_en_i  (wr_en_i),
    .wr_data_i(wr_data_i),
    .ctl_o    (ctl),
    .restart_o(restart)
  );

  always_comb begin
    os_div   = OS_DIV_W'(presc_of(ctl.psel)) << ctl.rsel;
    period_o = PER_W'(os_div) << OS_LOG2;
  end

  sci_rate_os_div #(.DIV_W(OS_DIV_W)) u_os (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(restart),
    .div_i    (os_div),
    .tick_o   (os_tick_o)
  );

  sci_rate_bit_div #(.OS_LOG2(OS_LOG2)) u_bit (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (restart),
    .os_tick_i (os_tick_o),
    .bit_tick_o(bit_tick_o)
  );

  assign rd_data_o = ctl;

endmodule

// File: rtl/sci_rate_gen_chk.sv
module sci_rate_gen_chk #(
  parameter int unsigned PER_W   = 15,
  parameter int unsigned OS_LOG2 = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [7:0]       rd_data_o,
  input logic [PER_W-1:0] period_o,
  input logic             os_tick_o,
  input logic             bit_tick_o
);

  localparam logic [PER_W-1:0] UNIT = PER_W'(1) << OS_LOG2;

  logic live_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) live_q <= 1'b0;
    else         live_q <= 1'b1;
  end

  // R6
  bit_in_os_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_tick_o |-> os_tick_o);

  // R4
  period_mult_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_o != '0) && (period_o[OS_LOG2-1:0] == '0));

  // R4
  period_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && !$stable(period_o)) |-> !$stable(rd_data_o));

  // R5
  os_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (os_tick_o && period_o != UNIT && !wr_en_i) |=> !os_tick_o);

  // R7
  restart_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (live_q && $past(wr_en_i) && period_o != UNIT) |-> !os_tick_o);

endmodule

bind sci_rate_gen sci_rate_gen_chk #(.PER_W(PER_W), .OS_LOG2(OS_LOG2)) chk_i (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .rd_data_o (rd_data_o),
  .period_o  (period_o),
  .os_tick_o (os_tick_o),
  .bit_tick_o(bit_tick_o)
);

// File: tb/sci_rate_gen_tb_top.sv
module sci_rate_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        boot_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [7:0]  wr_data_i = 8'h00;
  logic [7:0]  rd_data_o;
  logic [14:0] period_o;
  logic        os_tick_o;
  logic        bit_tick_o;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  sci_rate_gen dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .boot_i    (boot_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .period_o  (period_o),
    .os_tick_o (os_tick_o),
    .bit_tick_o(bit_tick_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int presc(input int code);
    case (code)
      0: return 1;
      1: return 3;
      2: return 4;
      default: return 13;
    endcase
  endfunction

  task automatic do_reset(input bit boot, input bit wr, input logic [7:0] d);
    @(negedge clk);
    rst_ni = 1'b0; boot_i = boot; wr_en_i = wr; wr_data_i = d;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // Ends at the negedge after the write edge: that sample is index 0.
  task automatic do_write(input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  // Counts negedge samples (index 0 = now) until the chosen strobe is high.
  task automatic wait_tick(input bit use_bit, input int limit, output int k);
    k = 0;
    while (((use_bit ? bit_tick_o : os_tick_o) !== 1'b1) && k < limit) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic t_reset();
    int k;
    bit all_hi;
    do_reset(1'b0, 1'b0, 8'h00);
    check(rd_data_o == 8'h00, "R1 reset byte", rd_data_o, 0);
    check(period_o == 15'd16, "R1 reset period", period_o, 16);
    all_hi = 1'b1;
    for (int i = 0; i < 15; i++) begin
      if (os_tick_o !== 1'b1) all_hi = 1'b0;
      if (bit_tick_o === 1'b1) all_hi = 1'b0;
      @(negedge clk);
    end
    check(all_hi, "R1 os strobe every cycle", all_hi, 1);
    check(bit_tick_o === 1'b1, "R1 bit strobe on 16th cycle", bit_tick_o, 1);
  endtask

  task automatic t_prescale();
    int k1, k2;
    for (int p = 0; p < 4; p++) begin
      int dv;
      dv = presc(p);
      do_write(8'(p << 4));
      check(period_o == 15'(dv * 16), "R2 period per prescale code", period_o, dv * 16);
      wait_tick(1'b0, 100, k1);
      check(k1 == dv - 1, "R2 first os strobe", k1, dv - 1);
      @(negedge clk);
      wait_tick(1'b0, 100, k2);
      check(k1 + 1 + k2 == 2 * dv - 1, "R5 os spacing", k1 + 1 + k2, 2 * dv - 1);
    end
  endtask

  task automatic t_rate();
    int k;
    for (int s = 0; s < 8; s++) begin
      do_write(8'(s));
      check(period_o == 15'(16 << s), "R3 period per rate code", period_o, 16 << s);
      wait_tick(1'b0, 300, k);
      check(k == (1 << s) - 1, "R3 first os strobe", k, (1 << s) - 1);
    end
  endtask

  task automatic t_combo();
    int k;
    do_write(8'h25);
    check(period_o == 15'd2048, "R4 combined period", period_o, 2048);
    wait_tick(1'b1, 3000, k);
    check(k == 2047, "R7 first bit strobe", k, 2047);
  endtask

  task automatic t_testbits();
    int k;
    do_write(8'h9A);
    check(rd_data_o == 8'h9A, "R8 test bits read back", rd_data_o, 8'h9A);
    check(period_o == 15'd192, "R8 period unaffected", period_o, 192);
    wait_tick(1'b0, 100, k);
    check(k == 11, "R8 strobe unaffected", k, 11);
  endtask

  task automatic t_restart();
    int k;
    do_write(8'h05);
    repeat (20) @(negedge clk);
    do_write(8'h05);
    wait_tick(1'b0, 100, k);
    check(k == 31, "R7 restart mid count", k, 31);
    do_write(8'h01);
    wait_tick(1'b1, 100, k);
    check(k == 31, "R7 restart bit counter", k, 31);
  endtask

  task automatic t_boot();
    int k;
    do_reset(1'b1, 1'b0, 8'h00);
    @(negedge clk);
    check(rd_data_o == 8'h33, "R9 boot preload byte", rd_data_o, 8'h33);
    check(period_o == 15'd1664, "R9 boot period", period_o, 1664);
    wait_tick(1'b0, 300, k);
    check(k == 103, "R9 boot first os strobe", k, 103);
    do_write(8'h00);
    repeat (3) @(negedge clk);
    check(rd_data_o == 8'h00, "R9 boot ignored later", rd_data_o, 0);
  endtask

  task automatic t_boot_write();
    do_reset(1'b1, 1'b1, 8'h01);
    @(negedge clk);
    wr_en_i = 1'b0;
    check(rd_data_o == 8'h01, "R10 write beats preload", rd_data_o, 1);
    repeat (3) @(negedge clk);
    check(rd_data_o == 8'h01, "R10 no late preload", rd_data_o, 1);
    boot_i = 1'b0;
  endtask

  initial begin
    t_reset();
    t_prescale();
    t_rate();
    t_combo();
    t_testbits();
    t_restart();
    t_boot();
    t_boot_write();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule